// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block controls the timing of a 10-bit successive-approximation analog-to-digital converter. A 3-bit speed code selects three lengths, all counted in system clock cycles: a start delay, a sampling window and a total conversion time. While the enable input is high, the block runs conversions one after another. Each conversion has a sampling phase, in which the sample-and-hold output is high, followed by ten comparison steps. The comparator is the only analog part the block sees, and it reaches the block as a single input bit. When each conversion ends, the block emits a one-cycle interrupt pulse and latches the converted code.

The sequence restarts with a fresh start delay in two cases: when the enable input goes from low to high, and when the channel-select register is rewritten while the block is enabled. The start delay is a per-code minimum plus the cycles left until the next boundary of a free-running prescaler. It therefore varies by a few cycles, but it always stays inside the window for that code.

The block also checks each bus access against the clock state. A result read, control write or channel write made while the CPU runs on the slow clock with the fast oscillator stopped is flagged as illegal. A channel write made in that state is also ignored.

The state machine has four states:
- `ST_IDLE`: nothing runs.
- `ST_DELAY`: the start delay is counting.
- `ST_SAMPLE`: the sample-and-hold output is high.
- `ST_CONVERT`: the bit steps are taking place.

It has these transitions:
- start: `ST_IDLE` to `ST_DELAY`, when the block is enabled and the speed code is legal.
- delay done: `ST_DELAY` to `ST_SAMPLE`.
- hold done: `ST_SAMPLE` to `ST_CONVERT`.
- finish: `ST_CONVERT` to `ST_SAMPLE`, which also fires the interrupt.
- restart: any active state to `ST_DELAY`, on a legal channel rewrite.
- stop: any state to `ST_IDLE`, when enable is low or when a rewrite carries an illegal code.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, `sample_hold`, `bit_step`, `eoc_irq` and `access_err` are 0 and `result` is 0.
- R2: After `en` is seen high in idle, `sample_hold` rises after a start delay whose length lies in a per-code window. The windows are 32..36 cycles for code 000, 28..32 for 001, 24..28 for 010, 16..18 for 100, 14..16 for 101 and 12..14 for 110.
- R3: `sample_hold` stays high for the code's sampling time: 40, 32, 24, 20, 16 or 12 cycles for codes 000, 001, 010, 100, 101 and 110.
- R4: `eoc_irq` is a single-cycle pulse that rises exactly one conversion time after `sample_hold` rose. The conversion times are 288, 240, 192, 144, 120 and 96 cycles for the same codes in the same order.
- R5: While enabled, the next sampling phase starts in the same cycle as `eoc_irq`, so successive interrupts are one conversion time apart.
- R6: During the conversion phase, `bit_step` pulses exactly ten times, MSB first, and never during sampling. At each step, the bit under trial in `trial_code` is kept if `cmp_in` is 1 and cleared if it is 0. `result` changes only when `eoc_irq` is high, and then it takes the final code.
- R7: Speed codes 011 and 111 never start a conversion: `sample_hold` and `eoc_irq` stay low.
- R8: Driving `en` low puts the block in idle at the next clock edge, with no further `eoc_irq` and no change to `result`.
- R9: A `chan_wr` pulse while enabled aborts the running conversion without an interrupt. `sample_hold` then rises again after a new start delay inside the R2 window.
- R10: `access_err` is 1 in the cycle after `rd_result`, `wr_ctrl` or `chan_wr` is high while both `slow_clk` and `fast_osc_off` are 1. Otherwise it is 0.
- R11: A `chan_wr` made while both `slow_clk` and `fast_osc_off` are 1 does not restart the sequence: the running conversion ends on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable level |
| chan_wr | input | 1 | Channel-select register write strobe |
| speed | input | 3 | Speed code selecting the timing set |
| cmp_in | input | 1 | Comparator result: input at or above trial code |
| slow_clk | input | 1 | CPU running on the slow clock |
| fast_osc_off | input | 1 | Fast oscillator stopped |
| rd_result | input | 1 | Result read strobe |
| wr_ctrl | input | 1 | Control register write strobe |
| sample_hold | output | 1 | Sample-and-hold switch closed |
| bit_step | output | 1 | Comparison step pulse |
| trial_code | output | 10 | Code applied to the DAC under test |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |
| result | output | 10 | Latched conversion result |
| access_err | output | 1 | Illegal bus access flag |

## Verification
All timings are counted in clock edges, and each check samples 1 ns after an edge.

- **Start delay:** `sample_hold` rises d+1 edges after `en` is applied, or d edges after a `chan_wr` edge. The bench checks only that d falls inside the code's window, because the exact value depends on the prescaler phase.
- **Sampling and conversion:** from the edge where `sample_hold` rises, it falls exactly after the sampling time. The interrupt appears exactly one conversion time after that same edge, and `result` is compared in that cycle.
- **Access flag:** `access_err` is checked one edge after the access is applied.
- **Disable and restart:** these are checked by watching for hundreds of cycles that no interrupt appears, and that `result` keeps its last value during that time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned CYC_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SAMPLE,
        ST_CONVERT
    } seq_state_t;

    typedef struct packed {
        logic             legal;
        logic             wide;
        logic [CYC_W-1:0] conv;
        logic [CYC_W-1:0] samp;
        logic [CYC_W-1:0] dmin;
        logic [CYC_W-1:0] step;
    } speed_cfg_t;

    // Timing set per speed code; step is the spacing of bit decisions.
    function automatic speed_cfg_t decode_speed(input logic [2:0] code,
                                                input int unsigned bits);
        speed_cfg_t c;
        c = '0;
        case (code)
            3'b000: begin c.legal = 1'b1; c.wide = 1'b1; c.conv = CYC_W'(288);
                          c.samp = CYC_W'(40); c.dmin = CYC_W'(32);
                          c.step = CYC_W'((288 - 40) / bits); end
            3'b001: begin c.legal = 1'b1; c.wide = 1'b1; c.conv = CYC_W'(240);
                          c.samp = CYC_W'(32); c.dmin = CYC_W'(28);
                          c.step = CYC_W'((240 - 32) / bits); end
            3'b010: begin c.legal = 1'b1; c.wide = 1'b1; c.conv = CYC_W'(192);
                          c.samp = CYC_W'(24); c.dmin = CYC_W'(24);
                          c.step = CYC_W'((192 - 24) / bits); end
            3'b100: begin c.legal = 1'b1; c.wide = 1'b0; c.conv = CYC_W'(144);
                          c.samp = CYC_W'(20); c.dmin = CYC_W'(16);
                          c.step = CYC_W'((144 - 20) / bits); end
            3'b101: begin c.legal = 1'b1; c.wide = 1'b0; c.conv = CYC_W'(120);
                          c.samp = CYC_W'(16); c.dmin = CYC_W'(14);
                          c.step = CYC_W'((120 - 16) / bits); end
            3'b110: begin c.legal = 1'b1; c.wide = 1'b0; c.conv = CYC_W'(96);
                          c.samp = CYC_W'(12); c.dmin = CYC_W'(12);
                          c.step = CYC_W'((96 - 12) / bits); end
            default: c.legal = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/adc_seq_prescaler.sv
module adc_seq_prescaler #(
    parameter int unsigned PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] to_wide,
    output logic          to_narrow
);

    logic [PW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + PW'(1);
    end

    // Cycles left to the next boundary of a 2^PW and of a 2-cycle period.
    assign to_wide   = PW'(0) - phase;
    assign to_narrow = phase[0];

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
    parameter int unsigned RES = 10,
    parameter int unsigned CW  = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           active,
    input  logic [CW-1:0]  step_len,
    input  logic           cmp_in,
    output logic [RES-1:0] trial,
    output logic           bit_step
);

    localparam int unsigned IDX_W = $clog2(RES);

    logic [CW-1:0]    step_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             done;

    assign bit_step = active && !done && (step_cnt == step_len - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial    <= '0;
            bit_idx  <= '0;
            step_cnt <= '0;
            done     <= 1'b1;
        end else if (load) begin
            trial    <= RES'(1) << (RES - 1);
            bit_idx  <= IDX_W'(RES - 1);
            step_cnt <= '0;
            done     <= 1'b0;
        end else if (active && !done) begin
            if (bit_step) begin
                step_cnt <= '0;
                if (!cmp_in) trial[bit_idx] <= 1'b0;
                if (bit_idx != '0) begin
                    trial[bit_idx - IDX_W'(1)] <= 1'b1;
                    bit_idx <= bit_idx - IDX_W'(1);
                end else begin
                    done <= 1'b1;
                end
            end else begin
                step_cnt <= step_cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_BITS = 10,
    parameter int unsigned PRESC_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                chan_wr,
    input  logic [2:0]          speed,
    input  logic                cmp_in,
    input  logic                slow_clk,
    input  logic                fast_osc_off,
    input  logic                rd_result,
    input  logic                wr_ctrl,
    output logic                sample_hold,
    output logic                bit_step,
    output logic [RES_BITS-1:0] trial_code,
    output logic                eoc_irq,
    output logic [RES_BITS-1:0] result,
    output logic                access_err
);

    localparam int unsigned CW = CYC_W;

    seq_state_t          state, nxt;
    logic [CW-1:0]       cnt, nxt_cnt;
    logic [CW-1:0]       cfg_samp, cfg_conv, cfg_step;
    logic [CW-1:0]       delay_len;
    speed_cfg_t          live;
    logic [PRESC_W-1:0]  ext_wide;
    logic                ext_narrow;
    logic                blocked, load_cfg, fire, sar_load, converting;
    logic [RES_BITS-1:0] trial;

    assign live    = decode_speed(speed, RES_BITS);
    assign blocked = slow_clk & fast_osc_off;

    adc_seq_prescaler #(.PW(PRESC_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .to_wide   (ext_wide),
        .to_narrow (ext_narrow)
    );

    assign delay_len = live.dmin + (live.wide ? CW'(ext_wide) : CW'(ext_narrow));

    // Next-state logic: disable first, then (re)start, then phase counting.
    always_comb begin
        nxt      = state;
        nxt_cnt  = cnt;
        load_cfg = 1'b0;
        fire     = 1'b0;
        if (!en) begin
            nxt     = ST_IDLE;
            nxt_cnt = '0;
        end else if (state == ST_IDLE || (chan_wr && !blocked)) begin
            if (live.legal) begin
                nxt      = ST_DELAY;
                nxt_cnt  = delay_len - CW'(1);
                load_cfg = 1'b1;
            end else begin
                nxt     = ST_IDLE;
                nxt_cnt = '0;
            end
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_DELAY: begin
                    if (cnt == '0) begin
                        nxt     = ST_SAMPLE;
                        nxt_cnt = cfg_samp - CW'(1);
                    end else begin
                        nxt_cnt = cnt - CW'(1);
                    end
                end
                ST_SAMPLE: begin
                    if (cnt == '0) begin
                        nxt     = ST_CONVERT;
                        nxt_cnt = cfg_conv - cfg_samp - CW'(1);
                    end else begin
                        nxt_cnt = cnt - CW'(1);
                    end
                end
                ST_CONVERT: begin
                    if (cnt == '0) begin
                        nxt     = ST_SAMPLE;
                        nxt_cnt = cfg_samp - CW'(1);
                        fire    = 1'b1;
                    end else begin
                        nxt_cnt = cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    // State register with the timing set captured at each (re)start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cfg_samp <= '0;
            cfg_conv <= '0;
            cfg_step <= '0;
        end else begin
            state <= nxt;
            cnt   <= nxt_cnt;
            if (load_cfg) begin
                cfg_samp <= live.samp;
                cfg_conv <= live.conv;
                cfg_step <= live.step;
            end
        end
    end

    assign sar_load   = (state == ST_SAMPLE) && (nxt == ST_CONVERT);
    assign converting = (state == ST_CONVERT);

    adc_seq_sar #(.RES(RES_BITS), .CW(CW)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sar_load),
        .active   (converting),
        .step_len (cfg_step),
        .cmp_in   (cmp_in),
        .trial    (trial),
        .bit_step (bit_step)
    );

    assign trial_code = trial;

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_irq    <= 1'b0;
            result     <= '0;
            access_err <= 1'b0;
        end else begin
            eoc_irq    <= fire;
            if (fire) result <= trial;
            access_err <= blocked & (rd_result | wr_ctrl | chan_wr);
        end
    end

    always_comb sample_hold = (state == ST_SAMPLE);

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic                chan_wr,
    input logic [2:0]          speed,
    input logic                slow_clk,
    input logic                fast_osc_off,
    input logic                rd_result,
    input logic                wr_ctrl,
    input logic                sample_hold,
    input logic                bit_step,
    input logic                eoc_irq,
    input logic [RES_BITS-1:0] result,
    input logic                access_err,
    input seq_state_t          state
);

    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    p_next_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> sample_hold);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_irq |-> $stable(result));

    p_no_step_sampling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_step |-> !sample_hold);

    p_illegal_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && (speed == 3'b011 || speed == 3'b111)) |=> state == ST_IDLE);

    p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE && !eoc_irq));

    p_access_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_clk && fast_osc_off && (rd_result || wr_ctrl || chan_wr)) |=> access_err);

    p_blocked_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slow_clk && fast_osc_off && state == ST_SAMPLE) |=> state != ST_DELAY);

endmodule

bind adc_conv_sequencer adc_seq_checker #(.RES_BITS(RES_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .chan_wr      (chan_wr),
    .speed        (speed),
    .slow_clk     (slow_clk),
    .fast_osc_off (fast_osc_off),
    .rd_result    (rd_result),
    .wr_ctrl      (wr_ctrl),
    .sample_hold  (sample_hold),
    .bit_step     (bit_step),
    .eoc_irq      (eoc_irq),
    .result       (result),
    .access_err   (access_err),
    .state        (state)
);

// File: tb/adc_conv_sequencer_test.sv
`timescale 1ns/1ps
module adc_conv_sequencer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, chan_wr = 1'b0, cmp_in;
    logic [2:0] speed = 3'b000;
    logic       slow_clk = 1'b0, fast_osc_off = 1'b0, rd_result = 1'b0, wr_ctrl = 1'b0;
    logic       sample_hold, bit_step, eoc_irq, access_err;
    logic [9:0] trial_code, result;
    logic [9:0] target = '0;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    assign cmp_in = (target >= trial_code);

    adc_conv_sequencer uut (
        .clk(clk), .rst_n(rst_n), .en(en), .chan_wr(chan_wr), .speed(speed),
        .cmp_in(cmp_in), .slow_clk(slow_clk), .fast_osc_off(fast_osc_off),
        .rd_result(rd_result), .wr_ctrl(wr_ctrl), .sample_hold(sample_hold),
        .bit_step(bit_step), .trial_code(trial_code), .eoc_irq(eoc_irq),
        .result(result), .access_err(access_err)
    );

    function automatic int e_conv(input logic [2:0] c);
        case (c) 3'd0: return 288; 3'd1: return 240; 3'd2: return 192;
                 3'd4: return 144; 3'd5: return 120; 3'd6: return 96;
                 default: return 0; endcase
    endfunction
    function automatic int e_samp(input logic [2:0] c);
        case (c) 3'd0: return 40; 3'd1: return 32; 3'd2: return 24;
                 3'd4: return 20; 3'd5: return 16; 3'd6: return 12;
                 default: return 0; endcase
    endfunction
    function automatic int e_dmin(input logic [2:0] c);
        case (c) 3'd0: return 32; 3'd1: return 28; 3'd2: return 24;
                 3'd4: return 16; 3'd5: return 14; 3'd6: return 12;
                 default: return 0; endcase
    endfunction
    function automatic int e_dmax(input logic [2:0] c);
        case (c) 3'd0: return 36; 3'd1: return 32; 3'd2: return 28;
                 3'd4: return 18; 3'd5: return 16; 3'd6: return 14;
                 default: return 0; endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        while (!sample_hold && n < 2000) begin tick(); n++; end
    endtask

    task automatic measure_sample(output int w);
        w = 0;
        while (sample_hold && w < 2000) begin tick(); w++; end
    endtask

    // Counts edges from the sample_hold rise (already 'done' edges elapsed) to eoc.
    task automatic measure_conv(input int done, output int c, output int steps);
        c = done;
        steps = 0;
        while (!eoc_irq && c < 2000) begin
            if (bit_step) steps++;
            tick();
            c++;
        end
    endtask

    task automatic run_conv(input logic [2:0] code, input logic [9:0] t1, input logic [9:0] t2);
        int n, w, c, s;
        en = 1'b0; tick();
        speed = code; target = t1; en = 1'b1;
        wait_rise(n);
        chk((n - 1) >= e_dmin(code) && (n - 1) <= e_dmax(code), "R2 start delay", n - 1, e_dmin(code));
        measure_sample(w);
        chk(w == e_samp(code), "R3 sampling time", w, e_samp(code));
        measure_conv(w, c, s);
        chk(c == e_conv(code), "R4 conversion time", c, e_conv(code));
        chk(s == 10, "R6 bit step count", s, 10);
        chk(result == t1, "R6 result", int'(result), int'(t1));
        chk(sample_hold == 1'b1, "R5 next sample with irq", int'(sample_hold), 1);
        target = t2;
        tick();
        chk(eoc_irq == 1'b0, "R4 single-cycle irq", int'(eoc_irq), 0);
        measure_conv(1, c, s);
        chk(c == e_conv(code), "R5 back-to-back period", c, e_conv(code));
        chk(result == t2, "R6 second result", int'(result), int'(t2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [2:0] legal_codes [6] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};
        int n, w, c, s, seen;
        logic [9:0] r0;
        void'($urandom(32'h5eed_1234));

        repeat (3) tick();
        chk(!sample_hold && !eoc_irq && !access_err && !bit_step && result == 0,
            "R1 reset state", int'(result), 0);
        rst_n = 1'b1;
        tick();
        chk(!sample_hold && !eoc_irq && !access_err && result == 0,
            "R1 after reset", int'(result), 0);

        // R6 corner codes
        run_conv(3'd6, 10'd0, 10'd1023);
        run_conv(3'd0, 10'd512, 10'd511);

        // Constrained random legal codes and targets
        for (int i = 0; i < 8; i++) begin
            run_conv(legal_codes[$urandom % 6], 10'($urandom), 10'($urandom));
        end

        // R7 illegal codes
        for (int k = 0; k < 2; k++) begin
            en = 1'b0; tick();
            speed = (k == 0) ? 3'b011 : 3'b111; en = 1'b1;
            seen = 0;
            for (int j = 0; j < 500; j++) begin
                tick();
                if (sample_hold || eoc_irq) seen++;
            end
            chk(seen == 0, "R7 illegal code idle", seen, 0);
        end

        // R8 disable mid-conversion
        en = 1'b0; tick();
        speed = 3'd6; target = 10'd77; en = 1'b1;
        wait_rise(n);
        measure_sample(w);
        repeat (5) tick();
        r0 = result;
        en = 1'b0;
        tick();
        chk(sample_hold == 1'b0, "R8 idle after disable", int'(sample_hold), 0);
        seen = 0;
        for (int j = 0; j < 400; j++) begin
            tick();
            if (eoc_irq || sample_hold) seen++;
        end
        chk(seen == 0, "R8 no activity after disable", seen, 0);
        chk(result == r0, "R8 result unchanged", int'(result), int'(r0));

        // R9 channel rewrite restarts
        run_conv(3'd1, 10'd300, 10'd301);
        target = 10'd900;
        measure_sample(w);
        repeat (30) tick();
        r0 = result;
        chan_wr = 1'b1;
        tick();
        chan_wr = 1'b0;
        chk(sample_hold == 1'b0, "R9 restart enters delay", int'(sample_hold), 0);
        seen = 0;
        n = 0;
        while (!sample_hold && n < 2000) begin
            if (eoc_irq) seen++;
            tick(); n++;
        end
        chk(n >= e_dmin(3'd1) && n <= e_dmax(3'd1), "R9 fresh start delay", n, e_dmin(3'd1));
        chk(seen == 0 && result == r0, "R9 aborted conversion silent", int'(result), int'(r0));
        measure_sample(w);
        measure_conv(w, c, s);
        chk(c == e_conv(3'd1) && result == 10'd900, "R9 conversion after restart", int'(result), 900);

        // R10 access flag
        slow_clk = 1'b1; fast_osc_off = 1'b0; rd_result = 1'b1;
        tick();
        chk(access_err == 1'b0, "R10 fast oscillator running", int'(access_err), 0);
        fast_osc_off = 1'b1;
        tick();
        chk(access_err == 1'b1, "R10 blocked read", int'(access_err), 1);
        rd_result = 1'b0; wr_ctrl = 1'b1;
        tick();
        chk(access_err == 1'b1, "R10 blocked control write", int'(access_err), 1);
        wr_ctrl = 1'b0; slow_clk = 1'b0; fast_osc_off = 1'b0;
        tick();
        chk(access_err == 1'b0, "R10 no access", int'(access_err), 0);

        // R11 blocked channel write is ignored
        en = 1'b0; tick();
        speed = 3'd4; target = 10'd640; en = 1'b1;
        wait_rise(n);
        c = 0;
        while (!eoc_irq && c < 2000) begin
            if (c == e_samp(3'd4) + 20) begin
                slow_clk = 1'b1; fast_osc_off = 1'b1; chan_wr = 1'b1;
            end
            if (c == e_samp(3'd4) + 21) begin
                chk(access_err == 1'b1, "R10 blocked channel write flagged", int'(access_err), 1);
                slow_clk = 1'b0; fast_osc_off = 1'b0; chan_wr = 1'b0;
            end
            tick();
            c++;
        end
        chk(c == e_conv(3'd4), "R11 blocked rewrite ignored", c, e_conv(3'd4));
        chk(result == 10'd640, "R11 result", int'(result), 640);

        en = 1'b0;
        repeat (3) tick();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule